// File: doc/BRIEF.md
# Address Phase Driver for Single and Dual Address Cycles

This block drives the address phase of a 64-bit capable PCI master. When a transaction is requested it chooses between one address phase and two. One phase (single address cycle) is used when the upper half of the address is zero. Two phases (dual address cycle) are used when the upper half is nonzero. For each phase it places the right values on the AD and C/BE lanes. It then raises a one-cycle handoff strobe that tells the data-phase logic it may start, together with a count of the address phases that were issued.

In a dual cycle the first phase carries the lower address half and the dual-cycle command code on the low lanes. The second phase carries the upper address half and the real memory command. With the 64-bit extension enabled, the upper address half and the real command are also driven on the high lanes in both phases, so a wide target can decode after the first phase. A narrow target still sees the full address and command over the two phases. When the high lanes carry nothing meaningful, they are parked at fixed levels.

Top module: `dac_addr_driver`

## Requirements
- R1: While reset is held and in the first cycle after it, `ad_o` is 0, `cbe_o` is 8'hFF, `addr_phase_o` is 0, `data_go_o` is 0 and `phase_cnt_o` is 0.
- R2: A request accepted with `addr_i[63:32]` equal to zero gives exactly one address phase in the cycle after the accepting edge. In that phase `ad_o[31:0]` is `addr_i[31:0]` and `cbe_o[3:0]` is `cmd_i`.
- R3: During a single-cycle address phase, `ad_o[63:32]` is zero and `cbe_o[7:4]` is 4'b1111, whatever the value of `wide_i`.
- R4: A request with a nonzero upper half gives two consecutive address phases. In the first, `ad_o[31:0]` is the lower half and `cbe_o[3:0]` is 4'b1101. In the second, `ad_o[31:0]` is the upper half and `cbe_o[3:0]` is `cmd_i`.
- R5: In a dual cycle with `wide_i` = 1, both phases carry `ad_o[63:32]` = `addr_i[63:32]` and `cbe_o[7:4]` = `cmd_i`.
- R6: In a dual cycle with `wide_i` = 0, both phases carry `ad_o[63:32]` = 0 and `cbe_o[7:4]` = 4'b1111.
- R7: `data_go_o` is 1 for exactly the one cycle after the last address phase. In that cycle `phase_cnt_o` is 1 for a single cycle and 2 for a dual cycle, and the block is idle the cycle after.
- R8: `start_i` is ignored while a transaction is in its address or handoff cycles. The address, command and width in use do not change, and a new request is accepted only once the block is idle again.
- R9: `addr_phase_o` is 1 exactly during the address phases. The first phase follows the clock edge at which `start_i` is seen high in idle.
- R10: When idle, `ad_o` is 0, `cbe_o` is 8'hFF and `phase_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin an address phase, taken only when idle |
| addr_i | input | 64 | Full transaction address |
| cmd_i | input | 4 | Memory bus command |
| wide_i | input | 1 | 64-bit extension in use for this transaction |
| ad_o | output | 64 | Address lanes |
| cbe_o | output | 8 | Command / byte-enable lanes |
| addr_phase_o | output | 1 | An address phase is being driven |
| data_go_o | output | 1 | One-cycle strobe: the data phase may begin |
| phase_cnt_o | output | 2 | Address phases used, valid while data_go_o is 1 |

## Verification
The handoff strobe of one transaction and the arrival of the next request can fall in the same cycle. Once a held request meets the end of an address sequence, the block has to finish the handoff and return to idle before it takes the new address. The bench provokes this by raising `start_i` with a different address during the first phase of a wide dual cycle and holding it through the handoff cycle. It judges that the second phase still shows the old upper half, that the cycle after the handoff is idle, and that only the following cycle shows the new address.

// File: rtl/dac_drv_pkg.sv
// Package: shared types and constants for the address-phase driver.
// Assumes a 4-bit bus command and a 64-bit address split into two halves.
package dac_drv_pkg;
    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] DUAL_CMD = 4'b1101;
    localparam logic [CMD_W-1:0] PARK_CBE = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2,
        ST_DATA = 2'd3
    } phase_e;
endpackage

// File: rtl/dac_req_capture.sv
// Module: holds the address, command and width of the accepted request.
// Assumes load_i is only raised when the sequencer is idle; the held
// values stay frozen for the whole transaction.
module dac_req_capture
    import dac_drv_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              wide_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              wide_q,
    output logic              dual_q
);
    localparam int HALF = ADDR_W / 2;

    // Register the request fields at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            wide_q <= 1'b0;
        end else if (load_i) begin
            addr_q <= addr_i;
            cmd_q  <= cmd_i;
            wide_q <= wide_i;
        end
    end

    // A dual cycle is needed whenever the upper half is nonzero.
    always_comb dual_q = |addr_q[ADDR_W-1:HALF];

    // R8
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(addr_q) && $stable(cmd_q) && $stable(wide_q)));
endmodule

// File: rtl/dac_phase_fsm.sv
// Module: sequences idle, one or two address phases and the handoff cycle.
// Assumes dual_i is valid from the cycle after the accepting edge.
module dac_phase_fsm
    import dac_drv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   dual_i,
    output phase_e state_o,
    output logic   load_o,
    output logic   busy_o,
    output logic   addr_phase_o,
    output logic   data_go_o
);
    phase_e nxt;

    // Accept a request only in idle.
    always_comb load_o = start_i && (state_o == ST_IDLE);

    // Next-state choice.
    always_comb begin
        nxt = state_o;
        unique case (state_o)
            ST_IDLE: if (start_i) nxt = ST_PH1;
            ST_PH1:  nxt = dual_i ? ST_PH2 : ST_DATA;
            ST_PH2:  nxt = ST_DATA;
            ST_DATA: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= nxt;
    end

    // Status decode.
    always_comb begin
        busy_o       = (state_o != ST_IDLE);
        addr_phase_o = (state_o == ST_PH1) || (state_o == ST_PH2);
        data_go_o    = (state_o == ST_DATA);
    end

    // R7
    go_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_go_o |-> $past(addr_phase_o));

    // R7
    go_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_go_o |=> !data_go_o && !addr_phase_o);

    // R9
    phase_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase_o && !$past(addr_phase_o)) |-> $past(start_i));
endmodule

// File: rtl/dac_lane_mux.sv
// Module: places address and command values on the AD and C/BE lanes for
// the current phase. Assumes the held request fields do not change while
// a transaction is under way.
module dac_lane_mux
    import dac_drv_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            state_i,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic              wide_q,
    input  logic              dual_q,
    output logic [ADDR_W-1:0] ad_o,
    output logic [2*CMD_W-1:0] cbe_o,
    output logic [1:0]        phase_cnt_o
);
    localparam int HALF = ADDR_W / 2;

    logic [HALF-1:0]  ad_lo, ad_hi;
    logic [CMD_W-1:0] cbe_lo, cbe_hi;
    logic             hi_live;

    // High lanes carry real content only in a wide dual cycle.
    always_comb hi_live = wide_q && dual_q;

    // Low-lane selection per phase.
    always_comb begin
        ad_lo  = '0;
        cbe_lo = PARK_CBE;
        unique case (state_i)
            ST_PH1: begin
                ad_lo  = addr_q[HALF-1:0];
                cbe_lo = dual_q ? DUAL_CMD : cmd_q;
            end
            ST_PH2: begin
                ad_lo  = addr_q[ADDR_W-1:HALF];
                cbe_lo = cmd_q;
            end
            default: ;
        endcase
    end

    // High-lane selection: upper half and command, or parked levels.
    always_comb begin
        ad_hi  = '0;
        cbe_hi = PARK_CBE;
        if (hi_live && (state_i == ST_PH1 || state_i == ST_PH2)) begin
            ad_hi  = addr_q[ADDR_W-1:HALF];
            cbe_hi = cmd_q;
        end
    end

    // Assemble the lanes and the phase count.
    always_comb begin
        ad_o        = {ad_hi, ad_lo};
        cbe_o       = {cbe_hi, cbe_lo};
        phase_cnt_o = (state_i != ST_DATA) ? 2'd0 : (dual_q ? 2'd2 : 2'd1);
    end

    // R3
    sac_high_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_PH1 && !dual_q) |->
            (ad_o[ADDR_W-1:HALF] == '0 && cbe_o[2*CMD_W-1:CMD_W] == PARK_CBE));

    // R4
    dual_first_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_PH2) |-> ($past(cbe_o[CMD_W-1:0]) == DUAL_CMD));

    // R5
    wide_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_PH2 && wide_q) |->
            ($stable(ad_o[ADDR_W-1:HALF]) && $stable(cbe_o[2*CMD_W-1:CMD_W])));

    // R10
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE) |-> (ad_o == '0 && cbe_o == '1 && phase_cnt_o == 2'd0));
endmodule

// File: rtl/dac_addr_driver.sv
// Module: top of the address-phase driver. Chooses single or dual address
// cycles, drives the lanes for each phase and signals the data handoff.
// Assumes requests are held by the caller only as long as it wishes; a
// request seen outside idle is dropped.
module dac_addr_driver
    import dac_drv_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        cmd_i,
    input  logic              wide_i,
    output logic [ADDR_W-1:0] ad_o,
    output logic [7:0]        cbe_o,
    output logic              addr_phase_o,
    output logic              data_go_o,
    output logic [1:0]        phase_cnt_o
);
    phase_e            state;
    logic              load, busy, dual_q, wide_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;

    dac_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .dual_i       (dual_q),
        .state_o      (state),
        .load_o       (load),
        .busy_o       (busy),
        .addr_phase_o (addr_phase_o),
        .data_go_o    (data_go_o)
    );

    dac_req_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .busy_i (busy),
        .addr_i (addr_i),
        .cmd_i  (cmd_i),
        .wide_i (wide_i),
        .addr_q (addr_q),
        .cmd_q  (cmd_q),
        .wide_q (wide_q),
        .dual_q (dual_q)
    );

    dac_lane_mux #(.ADDR_W(ADDR_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .addr_q      (addr_q),
        .cmd_q       (cmd_q),
        .wide_q      (wide_q),
        .dual_q      (dual_q),
        .ad_o        (ad_o),
        .cbe_o       (cbe_o),
        .phase_cnt_o (phase_cnt_o)
    );
endmodule

// File: tb/dac_addr_driver_tb.sv
module dac_addr_driver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {addr[63:0], cmd[3:0], wide}
    localparam logic [68:0] VECS [0:NVEC-1] = '{
        {64'h0000_0000_1234_5678, 4'h6, 1'b0},
        {64'h0000_0000_89AB_CDE0, 4'h7, 1'b1},
        {64'hDEAD_BEEF_0000_1000, 4'hC, 1'b0},
        {64'hCAFE_F00D_4000_0040, 4'hE, 1'b1},
        {64'h0000_0001_FFFF_FFF0, 4'h6, 1'b1},
        {64'hFFFF_FFFF_0000_0000, 4'h7, 1'b0},
        {64'h0000_0000_0000_0000, 4'hF, 1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, wide_i = 1'b0;
    logic [63:0] addr_i = '0;
    logic [3:0]  cmd_i = '0;
    logic [63:0] ad_o;
    logic [7:0]  cbe_o;
    logic        addr_phase_o, data_go_o;
    logic [1:0]  phase_cnt_o;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_addr_driver u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .cmd_i(cmd_i), .wide_i(wide_i), .ad_o(ad_o), .cbe_o(cbe_o),
        .addr_phase_o(addr_phase_o), .data_go_o(data_go_o),
        .phase_cnt_o(phase_cnt_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " R10 ad"}, ad_o, 64'd0);
        chk({tag, " R10 cbe"}, {56'd0, cbe_o}, 64'hFF);
        chk({tag, " R10 cnt"}, {62'd0, phase_cnt_o}, 64'd0);
        chk({tag, " R9 phase"}, {63'd0, addr_phase_o}, 64'd0);
    endtask

    // Check one phase: low/high lanes expected from the requirements.
    task automatic check_phase(input string tag, input logic [63:0] ead, input logic [7:0] ecbe);
        chk({tag, " R9 addr_phase"}, {63'd0, addr_phase_o}, 64'd1);
        chk({tag, " ad"}, ad_o, ead);
        chk({tag, " cbe"}, {56'd0, cbe_o}, {56'd0, ecbe});
        chk({tag, " R7 no go"}, {63'd0, data_go_o}, 64'd0);
    endtask

    task automatic run_txn(input logic [63:0] a, input logic [3:0] c, input logic w);
        logic        dual;
        logic [31:0] hi_ad;
        logic [3:0]  hi_cbe;
        dual   = (a[63:32] != 32'd0);
        hi_ad  = (dual && w) ? a[63:32] : 32'd0;
        hi_cbe = (dual && w) ? c : 4'hF;
        addr_i = a; cmd_i = c; wide_i = w; start_i = 1'b1;
        step();
        start_i = 1'b0;
        if (!dual) begin
            check_phase("R2 R3 sac", {32'd0, a[31:0]}, {4'hF, c});
        end else begin
            check_phase(w ? "R4 R5 dac ph1" : "R4 R6 dac ph1", {hi_ad, a[31:0]}, {hi_cbe, 4'b1101});
            step();
            check_phase(w ? "R4 R5 dac ph2" : "R4 R6 dac ph2", {hi_ad, a[63:32]}, {hi_cbe, c});
        end
        step();
        chk("R7 data_go", {63'd0, data_go_o}, 64'd1);
        chk("R7 phase_cnt", {62'd0, phase_cnt_o}, dual ? 64'd2 : 64'd1);
        step();
        chk("R7 go drops", {63'd0, data_go_o}, 64'd0);
        check_idle("R7 back idle");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state, including a request raised under reset
        @(negedge clk);
        start_i = 1'b1; addr_i = 64'hFFFF_0000_1111_2222; cmd_i = 4'h7; wide_i = 1'b1;
        step();
        chk("R1 ad", ad_o, 64'd0);
        chk("R1 cbe", {56'd0, cbe_o}, 64'hFF);
        chk("R1 go", {63'd0, data_go_o}, 64'd0);
        start_i = 1'b0;
        rst_n = 1'b1;
        step();
        check_idle("R1 after reset");

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            run_txn(VECS[i][68:5], VECS[i][4:1], VECS[i][0]);
        end

        // R8: second request held from phase 1 through handoff
        addr_i = 64'h1111_2222_3333_4444; cmd_i = 4'h6; wide_i = 1'b1; start_i = 1'b1;
        step();
        addr_i = 64'h0000_0000_ABCD_0000; cmd_i = 4'h7; wide_i = 1'b0;
        check_phase("R8 ph1", 64'h1111_2222_3333_4444, 8'h6D);
        step();
        check_phase("R8 ph2 unchanged", 64'h1111_2222_1111_2222, 8'h66);
        step();
        chk("R8 R7 go", {63'd0, data_go_o}, 64'd1);
        chk("R8 cnt", {62'd0, phase_cnt_o}, 64'd2);
        step();
        check_idle("R8 idle before restart");
        step();
        start_i = 1'b0;
        check_phase("R8 new request", 64'h0000_0000_ABCD_0000, 8'hF7);
        step();
        chk("R8 new go", {63'd0, data_go_o}, 64'd1);
        chk("R8 new cnt", {62'd0, phase_cnt_o}, 64'd1);
        step();

        // R1: reset in the middle of a dual cycle
        addr_i = 64'h0000_0002_0000_0008; cmd_i = 4'hC; wide_i = 1'b1; start_i = 1'b1;
        step();
        start_i = 1'b0;
        rst_n = 1'b0;
        step();
        chk("R1 mid reset go", {63'd0, data_go_o}, 64'd0);
        check_idle("R1 mid reset");
        rst_n = 1'b1;
        step();
        check_idle("R1 released");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule